// File: doc/BRIEF.md
# Radar Range-Cell Threshold Detector with Alternating Sweep Store

This block sits between a spectrum engine and a display raster. On the slow processing clock it receives one magnitude per spectrum bin, along with the bin index, a qualifier and a pulse that marks the end of a sweep. Each magnitude is compared with a threshold set on switches, which gives one detect bit per bin. Only the lower half of the spectrum is kept. Because the sampled signal is real, the upper half is a mirror image, so the 64 kept bins cover the 1200 m range at 18.75 m per cell.

The detect bits go into one of two banks. While one bank fills in bin order during the current sweep, the other bank holds the complete previous sweep. The display side reads that finished bank on its own, faster pixel clock, one range cell per address. At each end-of-sweep pulse the banks swap roles. The read side follows the swap only after the bank select has passed through a two-flop synchronizer.

Top module: `range_det_pingpong`

## Requirements
- R1: A stored detect bit is 1 exactly when the 8-bit unsigned magnitude is strictly greater than the 8-bit threshold. A magnitude equal to the threshold stores 0.
- R2: A sample whose bin index is 64 or higher (bin_i[6] set) writes nothing. In particular it does not alias onto bin index minus 64.
- R3: A sample presented with valid_i low writes nothing.
- R4: A qualified sample with bin index below 64 writes its detect bit to range cell bin_i[5:0] of the bank being filled, in any arrival order.
- R5: An end-of-sweep pulse swaps the banks. A sample presented in the same cycle as the pulse still belongs to the sweep that is ending. Within 3 write-clock cycles plus 4 read-clock cycles after the pulse, reads return the sweep just completed.
- R6: While a new sweep is filling, reads keep returning the previous complete sweep unchanged.
- R7: After reset, every range cell reads 0.
- R8: det_o presents the cell addressed by rd_addr_i at the previous rising edge of clk_rd_i (one read-clock cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr_i | input | 1 | Processing-domain clock |
| clk_rd_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| mag_i | input | 8 | Spectrum magnitude, unsigned |
| thr_i | input | 8 | Detection threshold, unsigned |
| bin_i | input | 7 | Spectrum bin index, 0 to 127 |
| valid_i | input | 1 | Qualifies mag_i and bin_i |
| sweep_end_i | input | 1 | One-cycle end-of-sweep pulse |
| rd_addr_i | input | 6 | Range cell to read, pixel domain |
| det_o | output | 1 | Detect bit of the addressed cell in the last complete sweep |

## Verification
The hardest case to reach is the read side looking at the completed bank while the other bank is being overwritten. The stimulus produces it by loading a sweep and swapping. It then writes half of a sweep with the opposite pattern and reads every cell before issuing the next pulse. Aliasing of ignored bins is probed by first writing a low-half cell as 0 and then presenting its mirror bin (index plus 64) with a full-scale magnitude. A cell that was written with 0 is likewise given a later unqualified full-scale sample. The equal-to-threshold boundary falls on every fourth cell of one sweep.

// File: rtl/det_pkg.sv
package det_pkg;
  parameter int unsigned FFT_BINS = 128;
  parameter int unsigned NUM_BINS = FFT_BINS / 2;
  parameter int unsigned MAG_W    = 8;
endpackage

// File: rtl/det_thresh_stage.sv
module det_thresh_stage #(
  parameter int unsigned MAG_W    = 8,
  parameter int unsigned BIN_W    = 7,
  parameter int unsigned NUM_BINS = 64,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [MAG_W-1:0]  thr_i,
  input  logic [BIN_W-1:0]  bin_i,
  input  logic              valid_i,
  input  logic              sweep_end_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_bit_o,
  output logic              sweep_end_o
);
  logic in_range;
  assign in_range = (bin_i < BIN_W'(NUM_BINS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_bit_o    <= 1'b0;
      sweep_end_o <= 1'b0;
    end else begin
      wr_en_o     <= valid_i && in_range;
      wr_addr_o   <= bin_i[ADDR_W-1:0];
      wr_bit_o    <= (mag_i > thr_i);
      sweep_end_o <= sweep_end_i;
    end
  end

  // R1
  equal_no_detect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_range && mag_i <= thr_i) |=> (wr_en_o && !wr_bit_o));
  // R2
  upper_bin_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bin_i >= BIN_W'(NUM_BINS)) |=> !wr_en_o);
  // R3
  invalid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_en_o);
endmodule

// File: rtl/det_bank_pair.sv
module det_bank_pair #(
  parameter int unsigned NUM_BINS = 64,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic                         wr_bit_i,
  input  logic                         swap_i,
  output logic                         fill_sel_o,
  output logic [1:0][NUM_BINS-1:0]     bank_o
);
  logic                     fill_sel_q;
  logic [1:0][NUM_BINS-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_sel_q <= 1'b0;
    else if (swap_i) fill_sel_q <= ~fill_sel_q;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[b] <= '0;
      else if (wr_en_i && (fill_sel_q == 1'(b))) bank_q[b][wr_addr_i] <= wr_bit_i;
    end
  end

  assign fill_sel_o = fill_sel_q;
  assign bank_o     = bank_q;

  // R4
  cell_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (bank_q[$past(fill_sel_q)][$past(wr_addr_i)] == $past(wr_bit_i)));
  // R5
  swap_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> (fill_sel_q != $past(fill_sel_q)));
endmodule

// File: rtl/det_sel_sync.sv
module det_sel_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/range_det_pingpong.sv
module range_det_pingpong
  import det_pkg::*;
#(
  parameter int unsigned P_FFT_BINS = det_pkg::FFT_BINS,
  parameter int unsigned P_MAG_W    = det_pkg::MAG_W,
  localparam int unsigned P_NUM_BINS = P_FFT_BINS / 2,
  localparam int unsigned BIN_W      = $clog2(P_FFT_BINS),
  localparam int unsigned ADDR_W     = $clog2(P_NUM_BINS)
) (
  input  logic              clk_wr_i,
  input  logic              clk_rd_i,
  input  logic              rst_ni,
  input  logic [P_MAG_W-1:0] mag_i,
  input  logic [P_MAG_W-1:0] thr_i,
  input  logic [BIN_W-1:0]  bin_i,
  input  logic              valid_i,
  input  logic              sweep_end_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              det_o
);
  logic                       wr_en, wr_bit, swap, fill_sel, rd_fill_sel;
  logic [ADDR_W-1:0]          wr_addr;
  logic [1:0][P_NUM_BINS-1:0] bank;
  logic                       det_q;

  det_thresh_stage #(
    .MAG_W(P_MAG_W), .BIN_W(BIN_W), .NUM_BINS(P_NUM_BINS), .ADDR_W(ADDR_W)
  ) u_thresh (
    .clk_i(clk_wr_i), .rst_ni(rst_ni), .mag_i(mag_i), .thr_i(thr_i),
    .bin_i(bin_i), .valid_i(valid_i), .sweep_end_i(sweep_end_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_bit_o(wr_bit), .sweep_end_o(swap)
  );

  det_bank_pair #(.NUM_BINS(P_NUM_BINS), .ADDR_W(ADDR_W)) u_banks (
    .clk_i(clk_wr_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_bit_i(wr_bit), .swap_i(swap), .fill_sel_o(fill_sel), .bank_o(bank)
  );

  det_sel_sync u_sync (
    .clk_i(clk_rd_i), .rst_ni(rst_ni), .d_i(fill_sel), .q_o(rd_fill_sel)
  );

  // Read side uses the bank the synchronized select says is not filling.
  always_ff @(posedge clk_rd_i or negedge rst_ni) begin
    if (!rst_ni) det_q <= 1'b0;
    else det_q <= bank[~rd_fill_sel][rd_addr_i];
  end

  assign det_o = det_q;
endmodule

// File: tb/range_det_pingpong_tb.sv
module range_det_pingpong_tb;
  logic       clk_wr = 1'b0, clk_rd = 1'b0, rst_n = 1'b0;
  logic [7:0] mag = '0, thr = '0;
  logic [6:0] bin = '0;
  logic       valid = 1'b0, sweep_end = 1'b0;
  logic [5:0] rd_addr = '0;
  logic       det;

  int n_chk = 0, n_fail = 0;
  bit fill_m [64];
  bit shown_m [64];
  bit done = 1'b0;

  always #(2.5ns) clk_rd = ~clk_rd;
  always #(20ns)  clk_wr = ~clk_wr;

  range_det_pingpong u_dut (
    .clk_wr_i(clk_wr), .clk_rd_i(clk_rd), .rst_ni(rst_n),
    .mag_i(mag), .thr_i(thr), .bin_i(bin), .valid_i(valid),
    .sweep_end_i(sweep_end), .rd_addr_i(rd_addr), .det_o(det)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int b, input int m, input bit v);
    @(negedge clk_wr);
    bin = 7'(b); mag = 8'(m); valid = v;
    if (v && b < 64) fill_m[b] = (8'(m) > thr);
    @(posedge clk_wr);
  endtask

  task automatic end_sweep();
    @(negedge clk_wr);
    valid = 1'b0; sweep_end = 1'b1;
    @(negedge clk_wr);
    sweep_end = 1'b0;
    foreach (fill_m[i]) shown_m[i] = fill_m[i];
    repeat (3) @(posedge clk_wr);
    repeat (4) @(posedge clk_rd);
  endtask

  task automatic read_cell(input int a, input string req);
    @(negedge clk_rd);
    rd_addr = 6'(a);
    @(posedge clk_rd);
    @(negedge clk_rd);
    check(req, int'(det), int'(shown_m[a]));
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 64; a++) read_cell(a, req);
  endtask

  // R7
  task automatic t_reset();
    foreach (shown_m[i]) shown_m[i] = 1'b0;
    read_all("R7 reset zero");
  endtask

  // R1 R2 R3 R4 R5 R8
  task automatic t_threshold();
    thr = 8'd100;
    for (int k = 0; k < 64; k++) begin
      case (k % 4)
        0: put(k, 101, 1'b1);
        1: put(k, 100, 1'b1);
        2: put(k, 255, 1'b1);
        default: put(k, 0, 1'b1);
      endcase
    end
    put(7 + 64, 255, 1'b1);
    put(5, 255, 1'b0);
    end_sweep();
    read_all("R1 R4 R5 R8 threshold sweep");
    read_cell(7, "R2 mirror bin ignored");
    read_cell(5, "R3 invalid ignored");
    read_cell(1, "R1 equal gives zero");
    read_cell(0, "R1 one above gives detect");
  endtask

  // R6 R5 R4
  task automatic t_overlap();
    thr = 8'd0;
    for (int k = 63; k >= 32; k--) put(k, 200, 1'b1);
    read_all("R6 previous sweep held");
    for (int k = 31; k >= 0; k--) put(k, 200, 1'b1);
    read_all("R6 previous sweep held after fill");
    end_sweep();
    read_all("R5 R4 descending sweep swapped in");
  endtask

  // R1 R5: full-scale at maximum threshold, plus sample coincident with pulse
  task automatic t_max_thr();
    thr = 8'd255;
    for (int k = 0; k < 63; k++) put(k, 255, 1'b1);
    @(negedge clk_wr);
    bin = 7'd63; mag = 8'd255; valid = 1'b1; thr = 8'd10;
    fill_m[63] = 1'b1;
    sweep_end = 1'b1;
    @(negedge clk_wr);
    sweep_end = 1'b0; valid = 1'b0;
    foreach (fill_m[i]) shown_m[i] = fill_m[i];
    repeat (3) @(posedge clk_wr);
    repeat (4) @(posedge clk_rd);
    read_all("R1 R5 max threshold sweep");
    read_cell(63, "R5 sample with pulse kept");
  endtask

  initial begin
    #(1ms);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_wr);
    @(negedge clk_wr);
    rst_n = 1'b1;
    repeat (2) @(posedge clk_rd);
    t_reset();
    t_threshold();
    t_overlap();
    t_max_thr();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule